// File: doc/BRIEF.md
# Dual-Format Stereo Audio Serial Receiver

This block deserialises a stereo PCM stream carried on three wires: a bit clock, a word-select line that frames the two channels, and a serial data line. All three are sampled on rising bit-clock edges. A static format input selects either MSB-first right-justified framing or I2S framing. A static word-length input sets the sample size to a value from 16 to 24 bits. In packed operation each channel gets exactly as many bit clocks as it has bits, so the word meets both edges of its word-select half at once. Both formats handle that case.

Completed left/right pairs are passed from the bit-clock domain into the system-clock domain through a toggle request/acknowledge handshake. Each request line passes through a two-flop synchroniser. The system side shows the pair on registered outputs and raises a one-cycle valid strobe for each pair. A mute input forces both output words to zero. The strobe keeps running while mute is high.

Top module: `aud_serial_rx`

## Requirements
- R1: While `rst` is high (with the bit clock running), `smp_left` and `smp_right` read zero and `smp_valid` is low.
- R2: With `fmt_i2s` = 0 (right-justified), the left word is the last N bits sampled while word-select is high before it falls. The right word is the last N bits sampled while it is low before it rises. Both are MSB first. Earlier padding bits in a half are ignored.
- R3: With `fmt_i2s` = 1 (I2S), the left channel is the half where word-select is low. The MSB of a word is the bit sampled on the second rising bit-clock edge of a half, that is, one edge after the edge that first sees the new word-select level. The next N-1 edges carry the remaining bits, MSB first. Bits after those are ignored.
- R4: An N-bit word appears MSB-aligned in the 24-bit outputs: word bit N-1 sits at output bit 23, and output bits 23-N down to 0 are zero.
- R5: The effective length N is `word_len` clamped to the range 16..24. A value below 16 acts as 16 and a value above 24 acts as 24.
- R6: Packed framing (16-bit words with exactly 16 bit clocks per half) is received correctly in both formats. In I2S the LSB then falls on the first edge of the following half.
- R7: A pair is emitted when a right word completes, but only if a left word was completed after the previous right word. A right word received with no left word before it is discarded.
- R8: Mute high makes both outputs zero from the next system clock edge on. Pairs that arrive while muted still strobe `smp_valid` and carry zero data. After mute drops, the outputs stay zero until the next pair arrives.
- R9: `smp_valid` is a single-cycle pulse. While mute is low, the outputs change only in a cycle where `smp_valid` is high.
- R10: A pair that completes while the previous pair's handshake is still outstanding is dropped. The outstanding pair is held stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (system domain; also synchronised into the bit-clock domain) |
| ser_bclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| ser_ws | input | 1 | Word-select / frame clock |
| ser_data | input | 1 | Serial audio data, MSB first |
| fmt_i2s | input | 1 | Framing select: 0 right-justified, 1 I2S |
| word_len | input | 5 | Word length in bits, clamped to 16..24 |
| mute | input | 1 | High forces both output words to zero |
| smp_left | output | 24 | Left sample, MSB-aligned |
| smp_right | output | 24 | Right sample, MSB-aligned |
| smp_valid | output | 1 | One-cycle strobe per delivered stereo pair |

## Verification
The hardest case to reach from the ports is the dropped pair. It needs a bit clock so fast that a whole frame finishes before the acknowledge has come back through both synchronisers. The bench drops the bit-clock half period to a fraction of a nanosecond and sends three packed frames back to back. It then checks that the first pair is delivered, the second is never seen and the third arrives. A second hard case is a stream that starts mid-frame. The bench releases reset with word-select set so that the first complete half is a right channel. It then checks that this orphan word produces no strobe.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  // Framing selected by the static format input.
  typedef enum logic {
    FMT_RJ  = 1'b0,
    FMT_I2S = 1'b1
  } frame_fmt_e;

endpackage

// File: rtl/aud_rx_sync2.sv
module aud_rx_sync2 #(
  parameter logic RST_V = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_V;
      q    <= RST_V;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int MAX_W = 24,
  parameter int LEN_W = 5
) (
  input  logic             bclk,
  input  logic             brst,
  input  frame_fmt_e       fmt,
  input  logic [LEN_W-1:0] len,
  input  logic             ws,
  input  logic             sdata,
  input  logic             ack_s,
  output logic [MAX_W-1:0] pair_l,
  output logic [MAX_W-1:0] pair_r,
  output logic             req_t
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic             primed;
  logic             ws_q;
  logic             armed;
  logic             ch_left;
  logic             have_left;
  logic [CNT_W-1:0] cnt;
  logic [MAX_W-1:0] sr;
  logic [MAX_W-1:0] cap_vec;
  logic [MAX_W-1:0] aligned;
  logic [MAX_W-1:0] left_stage;
  logic [LEN_W-1:0] shamt;
  logic             edge_ws;
  logic             cap_en;
  logic             cap_left;
  logic             busy;

  // A handshake is outstanding until the acknowledge toggle catches up.
  assign busy    = req_t ^ ack_s;
  assign edge_ws = primed && (ws != ws_q);
  assign shamt   = LEN_W'(MAX_W) - len;

  // Right-justified: the word is the tail of the shift history at the
  // word-select edge. I2S: the word is complete N edges after the edge.
  always_comb begin
    if (fmt == FMT_I2S) begin
      cap_vec  = {sr[MAX_W-2:0], sdata};
      cap_en   = (cnt == ({1'b0, len} - 1'b1));
      cap_left = ch_left;
    end else begin
      cap_vec  = sr;
      cap_en   = edge_ws && armed;
      cap_left = ws_q;
    end
  end

  // One shifter places the newest N bits at the top of the output word.
  assign aligned = cap_vec << shamt;

  always_ff @(posedge bclk) begin
    if (brst) begin
      primed     <= 1'b0;
      ws_q       <= 1'b0;
      armed      <= 1'b0;
      ch_left    <= 1'b0;
      have_left  <= 1'b0;
      cnt        <= CNT_SAT;
      sr         <= '0;
      left_stage <= '0;
      pair_l     <= '0;
      pair_r     <= '0;
      req_t      <= 1'b0;
    end else begin
      primed <= 1'b1;
      ws_q   <= ws;
      sr     <= {sr[MAX_W-2:0], sdata};

      if (edge_ws) begin
        armed   <= 1'b1;
        cnt     <= '0;
        ch_left <= ~ws;
      end else if (cnt != CNT_SAT) begin
        cnt <= cnt + 1'b1;
      end

      if (cap_en) begin
        if (cap_left) begin
          left_stage <= aligned;
          have_left  <= 1'b1;
        end else begin
          have_left <= 1'b0;
          if (have_left && !busy) begin
            pair_l <= left_stage;
            pair_r <= aligned;
            req_t  <= ~req_t;
          end
        end
      end
    end
  end

  // R10: no new request while one is in flight.
  p_no_req_while_busy_r10 : assert property (
    @(posedge bclk) disable iff (brst || !primed)
    busy |=> $stable(req_t)
  );

  // R10: the pair under transfer is frozen until acknowledged.
  p_pair_frozen_r10 : assert property (
    @(posedge bclk) disable iff (brst || !primed)
    busy |=> ($stable(pair_l) && $stable(pair_r))
  );

endmodule

// File: rtl/aud_rx_xfer.sv
module aud_rx_xfer #(
  parameter int MAX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_t,
  input  logic [MAX_W-1:0] pair_l,
  input  logic [MAX_W-1:0] pair_r,
  input  logic             mute,
  output logic             ack_t,
  output logic [MAX_W-1:0] out_l,
  output logic [MAX_W-1:0] out_r,
  output logic             valid
);

  logic req_s;
  logic seen;

  aud_rx_sync2 #(.RST_V(1'b0)) u_req (
    .clk (clk),
    .rst (rst),
    .d   (req_t),
    .q   (req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= 1'b0;
      valid <= 1'b0;
      out_l <= '0;
      out_r <= '0;
    end else begin
      valid <= 1'b0;
      if (req_s != seen) begin
        seen  <= req_s;
        valid <= 1'b1;
        out_l <= mute ? '0 : pair_l;
        out_r <= mute ? '0 : pair_r;
      end else if (mute) begin
        out_l <= '0;
        out_r <= '0;
      end
    end
  end

  assign ack_t = seen;

  // R8: mute clears both words by the next edge.
  p_mute_zero_r8 : assert property (
    @(posedge clk) disable iff (rst)
    mute |=> (out_l == '0 && out_r == '0)
  );

  // R9: the strobe never lasts two cycles.
  p_valid_single_r9 : assert property (
    @(posedge clk) disable iff (rst)
    valid |=> !valid
  );

  // R9: unmuted outputs move only together with the strobe.
  p_hold_between_r9 : assert property (
    @(posedge clk) disable iff (rst)
    !mute |=> (valid || ($stable(out_l) && $stable(out_r)))
  );

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter  int MAX_W = 24,
  parameter  int MIN_W = 16,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_bclk,
  input  logic             ser_ws,
  input  logic             ser_data,
  input  logic             fmt_i2s,
  input  logic [LEN_W-1:0] word_len,
  input  logic             mute,
  output logic [MAX_W-1:0] smp_left,
  output logic [MAX_W-1:0] smp_right,
  output logic             smp_valid
);

  logic             brst;
  logic             ack_t;
  logic             ack_s;
  logic             req_t;
  logic [MAX_W-1:0] pair_l;
  logic [MAX_W-1:0] pair_r;
  logic [LEN_W-1:0] len_eff;
  frame_fmt_e       fmt;

  assign fmt = frame_fmt_e'(fmt_i2s);

  // R5: lengths outside the supported range snap to the nearest limit.
  always_comb begin
    if (word_len < LEN_W'(MIN_W))      len_eff = LEN_W'(MIN_W);
    else if (word_len > LEN_W'(MAX_W)) len_eff = LEN_W'(MAX_W);
    else                               len_eff = word_len;
  end

  // Reset reaches the bit-clock domain through its own synchroniser.
  aud_rx_sync2 #(.RST_V(1'b1)) u_rst_sync (
    .clk (ser_bclk),
    .rst (1'b0),
    .d   (rst),
    .q   (brst)
  );

  aud_rx_sync2 #(.RST_V(1'b0)) u_ack_sync (
    .clk (ser_bclk),
    .rst (brst),
    .d   (ack_t),
    .q   (ack_s)
  );

  aud_rx_framer #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_framer (
    .bclk   (ser_bclk),
    .brst   (brst),
    .fmt    (fmt),
    .len    (len_eff),
    .ws     (ser_ws),
    .sdata  (ser_data),
    .ack_s  (ack_s),
    .pair_l (pair_l),
    .pair_r (pair_r),
    .req_t  (req_t)
  );

  aud_rx_xfer #(.MAX_W(MAX_W)) u_xfer (
    .clk    (clk),
    .rst    (rst),
    .req_t  (req_t),
    .pair_l (pair_l),
    .pair_r (pair_r),
    .mute   (mute),
    .ack_t  (ack_t),
    .out_l  (smp_left),
    .out_r  (smp_right),
    .valid  (smp_valid)
  );

endmodule

// File: tb/sim_aud_serial_rx.sv
`timescale 1ns/1ps
module sim_aud_serial_rx;

  logic        clk = 1'b0;
  logic        rst;
  logic        ser_bclk, ser_ws, ser_data;
  logic        fmt_i2s;
  logic [4:0]  word_len;
  logic        mute;
  logic [23:0] smp_left, smp_right;
  logic        smp_valid;

  always #4 clk = ~clk;  // 125 MHz

  aud_serial_rx u0 (
    .clk(clk), .rst(rst), .ser_bclk(ser_bclk), .ser_ws(ser_ws),
    .ser_data(ser_data), .fmt_i2s(fmt_i2s), .word_len(word_len),
    .mute(mute), .smp_left(smp_left), .smp_right(smp_right),
    .smp_valid(smp_valid)
  );

  typedef struct packed {
    logic        fmt;
    logic [4:0]  len;
    logic [5:0]  slot;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  // fmt, word_len, bit clocks per half, left word, right word
  localparam vec_t VECS [8] = '{
    '{1'b0, 5'd16, 6'd16, 24'h008001, 24'h007FFE},  // R2 R6 packed
    '{1'b0, 5'd24, 6'd32, 24'hA5C3F0, 24'h0F1E2D},  // R2 R4
    '{1'b0, 5'd20, 6'd32, 24'h0FEDCB, 24'h012345},  // R2 R4 padding
    '{1'b1, 5'd16, 6'd16, 24'h00C3A5, 24'h005A3C},  // R3 R6 packed
    '{1'b1, 5'd24, 6'd32, 24'h800001, 24'h7FFFFE},  // R3
    '{1'b1, 5'd18, 6'd24, 24'h02AAAA, 24'h015555},  // R3 R4
    '{1'b0, 5'd8,  6'd16, 24'h001234, 24'h00FEDC},  // R5 low clamp
    '{1'b1, 5'd31, 6'd32, 24'h135790, 24'h2468AC}   // R5 high clamp
  };

  int   nchk = 0;
  int   nfail = 0;
  int   ngot = 0;
  bit   done = 0;
  real  bhalf = 50.0;
  logic carry;
  logic [23:0] gl [16];
  logic [23:0] gr [16];

  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      gl[ngot % 16] = smp_left;
      gr[ngot % 16] = smp_right;
      ngot = ngot + 1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int eff_len(input logic [4:0] l);
    if (l < 16) return 16;
    if (l > 24) return 24;
    return int'(l);
  endfunction

  function automatic logic [23:0] expw(input logic [23:0] w, input int n);
    logic [23:0] m;
    m = (n >= 24) ? 24'hFFFFFF : ((24'h1 << n) - 24'h1);
    return (w & m) << (24 - n);
  endfunction

  task automatic send_bit(input logic ws, input logic d);
    ser_ws = ws; ser_data = d;
    #(bhalf); ser_bclk = 1'b1;
    #(bhalf); ser_bclk = 1'b0;
  endtask

  task automatic send_half(input logic ws, input logic [23:0] w, input int n, input int s);
    for (int i = 0; i < s; i++) begin
      logic d;
      if (fmt_i2s) begin
        if (i == 0)      d = carry;
        else if (i <= n) d = w[n-i];
        else             d = 1'b0;
      end else begin
        d = (i < s - n) ? 1'b0 : w[n-1-(i-(s-n))];
      end
      send_bit(ws, d);
    end
    carry = (fmt_i2s && n == s) ? w[0] : 1'b0;
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input int n, input int s);
    if (fmt_i2s) begin
      send_half(1'b0, l, n, s);
      send_half(1'b1, r, n, s);
    end else begin
      send_half(1'b1, l, n, s);
      send_half(1'b0, r, n, s);
    end
  endtask

  task automatic flush();
    if (fmt_i2s) begin
      send_bit(1'b0, carry);
      send_bit(1'b0, 1'b0);
      send_bit(1'b0, 1'b0);
    end else begin
      send_bit(1'b1, 1'b0);
      send_bit(1'b1, 1'b0);
    end
    carry = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset(input logic idle_ws);
    @(negedge clk); rst = 1'b1; carry = 1'b0;
    repeat (4) send_bit(idle_ws, 1'b0);
    @(negedge clk); rst = 1'b0;
    repeat (3) send_bit(idle_ws, 1'b0);
  endtask

  initial begin
    rst = 1'b1; mute = 1'b0; fmt_i2s = 1'b0; word_len = 5'd16;
    ser_bclk = 1'b0; ser_ws = 1'b0; ser_data = 1'b0; carry = 1'b0;

    // R1: reset state with the bit clock running
    repeat (4) send_bit(1'b0, 1'b1);
    @(negedge clk);
    check(32'(smp_left),  32'h0, "R1 left in reset");
    check(32'(smp_right), 32'h0, "R1 right in reset");
    check(32'(smp_valid), 32'h0, "R1 valid in reset");

    // Table walk: R2 R3 R4 R5 R6 R9
    for (int k = 0; k < 8; k++) begin
      int n; int base;
      fmt_i2s  = VECS[k].fmt;
      word_len = VECS[k].len;
      n = eff_len(VECS[k].len);
      do_reset(VECS[k].fmt);  // idle level opposite to the first half
      base = ngot;
      send_frame(VECS[k].l, VECS[k].r, n, int'(VECS[k].slot));
      flush();
      check(32'(ngot - base), 32'd1, $sformatf("R7 one pair, vector %0d", k));
      check(32'(gl[base % 16]), 32'(expw(VECS[k].l, n)), $sformatf("R2/R3 R4 R5 R6 left, vector %0d", k));
      check(32'(gr[base % 16]), 32'(expw(VECS[k].r, n)), $sformatf("R2/R3 R4 R5 R6 right, vector %0d", k));
      repeat (200) @(negedge clk);
      check(32'(smp_left), 32'(expw(VECS[k].l, n)), $sformatf("R9 left held, vector %0d", k));
      check(32'(ngot - base), 32'd1, $sformatf("R9 no extra strobe, vector %0d", k));
    end

    // R7: an orphan right word at the start must not form a pair
    begin
      int base;
      fmt_i2s = 1'b1; word_len = 5'd16;
      do_reset(1'b0);
      base = ngot;
      send_half(1'b1, 24'h000BAD, 16, 16);
      send_frame(24'h001357, 24'h002468, 16, 16);
      flush();
      check(32'(ngot - base), 32'd1, "R7 orphan right discarded");
      check(32'(gl[base % 16]), 32'h135700, "R7 left after orphan");
      check(32'(gr[base % 16]), 32'h246800, "R7 right after orphan");
    end

    // R8: mute behaviour
    begin
      int base;
      fmt_i2s = 1'b0; word_len = 5'd16;
      do_reset(1'b0);
      base = ngot;
      send_frame(24'h004321, 24'h00BEEF, 16, 16);
      flush();
      check(32'(smp_left), 32'h432100, "R8 unmuted pair passes");
      @(negedge clk); mute = 1'b1;
      @(negedge clk);
      check(32'(smp_left),  32'h0, "R8 mute clears left");
      check(32'(smp_right), 32'h0, "R8 mute clears right");
      send_frame(24'h001111, 24'h002222, 16, 16);
      flush();
      check(32'(ngot - base), 32'd2, "R8 strobe while muted");
      check(32'(gl[(base + 1) % 16]), 32'h0, "R8 muted pair left zero");
      check(32'(gr[(base + 1) % 16]), 32'h0, "R8 muted pair right zero");
      @(negedge clk); mute = 1'b0;
      repeat (20) @(negedge clk);
      check(32'(smp_left), 32'h0, "R8 zero held after unmute");
      send_frame(24'h00CAFE, 24'h00F00D, 16, 16);
      flush();
      check(32'(smp_left),  32'hCAFE00, "R8 data after unmute left");
      check(32'(smp_right), 32'hF00D00, "R8 data after unmute right");
    end

    // R10: bit clock outpaces the handshake, middle pair dropped
    begin
      int base; bit seen_p2;
      fmt_i2s = 1'b0; word_len = 5'd16;
      do_reset(1'b0);
      bhalf = 0.2;
      base = ngot;
      send_frame(24'h00A001, 24'h00A002, 16, 16);
      send_frame(24'h00B001, 24'h00B002, 16, 16);
      send_frame(24'h00C001, 24'h00C002, 16, 16);
      flush();
      bhalf = 50.0;
      check(32'(ngot - base), 32'd2, "R10 pair count under overrun");
      check(32'(gl[base % 16]), 32'hA00100, "R10 first pair delivered");
      check(32'(gr[(base + 1) % 16]), 32'hC00200, "R10 third pair delivered");
      seen_p2 = 0;
      for (int j = base; j < ngot; j++)
        if (gl[j % 16] == 24'hB00100) seen_p2 = 1;
      check(32'(seen_p2), 32'd0, "R10 busy pair dropped");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

endmodule